// File: doc/BRIEF.md
# Reciprocal Square Root Approximator

This block computes an approximate reciprocal square root of a single-precision floating-point operand. It is meant for graphics-style workloads that need many `1/sqrt(x)` values but can live without IEEE-exact rounding. With it, a divide followed by a square root becomes one short fixed-latency operation. The result only has to stay within an absolute error of 2^(E-21), where E is the unbiased exponent of the exact result. The mantissa is truncated, and there is no sticky or guard logic.

The operand's exponent is split by parity. An odd unbiased exponent moves one factor of two into the mantissa, so the reduced operand always lies in [1,4) and the result exponent is found by a halving shift. A table indexed by the parity bit and the leading mantissa bits gives a seed of about seven good bits. A chain of Newton-Raphson stages, each registered, then refines the seed with `y' = y*(3 - x*y*y)/2` in fixed point. A final stage normalises the result and substitutes the fixed results for special operands.

The pipeline accepts one operand per cycle with a valid strobe. There is no backpressure. The result appears a fixed number of cycles later with its own strobe. Operands whose exponent field is zero (zeros and denormals) are treated as zero of the same sign.

Top module: `rsq_unit`

## Requirements
- R1: With the default two refinement stages, `res_vld` is high exactly 4 cycles after each cycle in which `op_vld` was high and is low otherwise; one operand per cycle is accepted back to back.
- R2: For an operand with sign 0 and exponent field 1..254, the result has sign 0, both flags are 0, and |result - 1/sqrt(operand)| <= 2^(E-21), where E is the unbiased exponent of the exact reciprocal square root.
- R3: An operand with sign 0 and exponent field 0 (positive zero or denormal) gives 0x7F800000 with `res_divzero` set and `res_invalid` clear.
- R4: An operand with sign 1 and exponent field 0 gives 0xFF800000 with `res_divzero` set and `res_invalid` clear.
- R5: An operand with sign 1, exponent field 1..255 and not a NaN (negative normal or negative infinity) gives 0x7FC00000 with `res_invalid` set and `res_divzero` clear.
- R6: Positive infinity (0x7F800000) gives 0x00000000 with both flags clear.
- R7: A quiet NaN (exponent field 255, mantissa bit 22 set, either sign) gives 0x7FC00000 with both flags clear.
- R8: A signalling NaN (exponent field 255, mantissa bit 22 clear, mantissa nonzero, either sign) gives 0x7FC00000 with `res_invalid` set.
- R9: While reset is asserted, `res_vld`, `res_invalid` and `res_divzero` are 0 and `res_bits` is 0x00000000.
- R10: While `res_vld` is low, `res_bits`, `res_invalid` and `res_divzero` keep the values of the last valid result (or the reset values).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| op_vld | input | 1 | Operand strobe |
| op_bits | input | 32 | Single-precision operand |
| res_vld | output | 1 | Result strobe |
| res_bits | output | 32 | Single-precision approximate reciprocal square root |
| res_invalid | output | 1 | Invalid-operation flag for the result |
| res_divzero | output | 1 | Divide-by-zero flag for the result |

## Verification
The hardest case to reach from the ports is a refined value that ends up at the edge of the normalisation window. For a reduced operand just below 4, the true result sits a hair above one half, and the truncation in the Newton stages can push the fixed-point value under 0.5. The exponent must then drop by one. Random operands with full-range exponents and mantissas hit this only rarely. The stimulus therefore adds directed operands with all-ones mantissas and both exponent parities, and exact powers of two and four, next to random traffic that interleaves every special class at random valid density.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int RSQ_W      = 32;
  localparam int RSQ_XW     = 25;  // reduced operand, Q2.23
  localparam int RSQ_YW     = 31;  // estimate, Q1.30
  localparam int RSQ_YF     = 30;
  localparam int RSQ_SEED_W = 11;  // seed, Q1.10

  typedef enum logic [2:0] {
    CLS_NORM  = 3'd0,
    CLS_PZERO = 3'd1,
    CLS_NZERO = 3'd2,
    CLS_NEG   = 3'd3,
    CLS_PINF  = 3'd4,
    CLS_QNAN  = 3'd5,
    CLS_SNAN  = 3'd6
  } rsq_cls_e;

  typedef struct packed {
    rsq_cls_e           cls;
    logic [7:0]         ebase;
    logic [RSQ_XW-1:0]  xr;
    logic [RSQ_YW-1:0]  y;
  } rsq_data_t;

  // Midpoint reciprocal square root of one table bucket, Q1.10
  function automatic logic [RSQ_SEED_W-1:0] rsq_seed(input int idx, input int idx_w);
    longint k, mi, odd, num, q, r, t;
    k   = longint'(1) << (idx_w - 1);
    odd = longint'(idx) / k;
    mi  = longint'(idx) % k;
    num = ((odd != 0) ? k : 2 * k) << 20;
    q   = num / (2 * k + 2 * mi + 1);
    r   = 0;
    for (int b = 15; b >= 0; b--) begin
      t = r | (longint'(1) << b);
      if (t * t <= q) r = t;
    end
    return RSQ_SEED_W'(r);
  endfunction

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
  import rsq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [RSQ_W-1:0] in_op,
  output logic             vld_q,
  output rsq_data_t        dat_q
);

  localparam int ROM_N  = 2 ** IDX_W;
  localparam int MIDX_W = IDX_W - 1;

  logic [RSQ_SEED_W-1:0] rom [ROM_N];

  for (genvar gi = 0; gi < ROM_N; gi++) begin : g_rom
    localparam logic [RSQ_SEED_W-1:0] SEED_V = rsq_seed(gi, IDX_W);
    assign rom[gi] = SEED_V;
  end

  logic             sgn;
  logic [7:0]       efld;
  logic [22:0]      mfld;
  logic             u_odd;
  logic signed [9:0] u_s, half_s, base_s;
  logic [IDX_W-1:0] ridx;
  rsq_cls_e         cls_d;
  rsq_data_t        dat_d;

  assign sgn  = in_op[31];
  assign efld = in_op[30:23];
  assign mfld = in_op[22:0];

  always_comb begin
    if (efld == 8'hFF) begin
      if (mfld != 23'd0)  cls_d = mfld[22] ? CLS_QNAN : CLS_SNAN;
      else                cls_d = sgn ? CLS_NEG : CLS_PINF;
    end else if (efld == 8'h00) begin
      cls_d = sgn ? CLS_NZERO : CLS_PZERO;
    end else begin
      cls_d = sgn ? CLS_NEG : CLS_NORM;
    end
  end

  always_comb begin
    u_s    = signed'({2'b00, efld}) - 10'sd127;
    u_odd  = u_s[0];
    half_s = u_s >>> 1;
    base_s = 10'sd126 - half_s;
    ridx   = {u_odd, mfld[22 -: MIDX_W]};
    dat_d.cls   = cls_d;
    dat_d.ebase = 8'(base_s);
    dat_d.xr    = u_odd ? {1'b1, mfld, 1'b0} : {2'b01, mfld};
    dat_d.y     = {rom[ridx], {(RSQ_YW - RSQ_SEED_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) dat_q <= dat_d;
  end

  // Seed always lies in [0.5,1)
  p_seed_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && dat_q.cls == CLS_NORM |-> !dat_q.y[RSQ_YF] && dat_q.y[RSQ_YF-1]);

  // A zero class only follows a zero exponent field
  p_zero_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && efld != 8'h00 |=> dat_q.cls != CLS_PZERO && dat_q.cls != CLS_NZERO);

endmodule

// File: rtl/rsq_nr_step.sv
module rsq_nr_step
  import rsq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vld_in,
  input  rsq_data_t dat_in,
  output logic      vld_q,
  output rsq_data_t dat_q
);

  localparam int SQ_W = 2 * RSQ_YW;
  localparam int S_W  = 32;
  localparam int XS_W = RSQ_XW + S_W;
  localparam int P_W  = 34;
  localparam int YR_W = RSQ_YW + P_W;
  localparam logic [P_W-1:0] THREE = P_W'(3) << RSQ_YF;

  logic [SQ_W-1:0]   yy;
  logic [S_W-1:0]    s;
  logic [XS_W-1:0]   xs;
  logic [P_W-1:0]    p, r;
  logic [YR_W-1:0]   yr;
  logic [RSQ_YW-1:0] y_d;
  rsq_data_t         dat_d;

  always_comb begin
    yy  = {{(SQ_W-RSQ_YW){1'b0}}, dat_in.y} * {{(SQ_W-RSQ_YW){1'b0}}, dat_in.y};
    s   = S_W'(yy >> RSQ_YF);
    xs  = {{(XS_W-RSQ_XW){1'b0}}, dat_in.xr} * {{(XS_W-S_W){1'b0}}, s};
    p   = P_W'(xs >> 23);
    r   = THREE - p;
    yr  = {{(YR_W-RSQ_YW){1'b0}}, dat_in.y} * {{(YR_W-P_W){1'b0}}, r};
    y_d = RSQ_YW'(yr >> (RSQ_YF + 1));
    dat_d   = dat_in;
    dat_d.y = y_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_in;
  end

  always_ff @(posedge clk) begin
    if (vld_in) dat_q <= dat_d;
  end

  // Refined estimate stays inside [0.25,1)
  p_nr_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in && dat_in.cls == CLS_NORM |=> !dat_q.y[RSQ_YF] && dat_q.y[RSQ_YF-1 -: 2] != 2'b00);

endmodule

// File: rtl/rsq_pack.sv
module rsq_pack
  import rsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_in,
  input  rsq_data_t        dat_in,
  output logic             res_vld,
  output logic [RSQ_W-1:0] res_bits,
  output logic             res_invalid,
  output logic             res_divzero
);

  localparam logic [RSQ_W-1:0] QNAN_DFLT = 32'h7FC0_0000;
  localparam logic [RSQ_W-1:0] PINF      = 32'h7F80_0000;
  localparam logic [RSQ_W-1:0] NINF      = 32'hFF80_0000;

  logic [7:0]       e_n;
  logic [22:0]      m_n;
  logic [RSQ_W-1:0] bits_d;
  logic             inv_d, dz_d;
  logic             unused_xr;

  assign unused_xr = ^dat_in.xr;

  always_comb begin
    if (dat_in.y[RSQ_YF]) begin
      e_n = dat_in.ebase + 8'd1;
      m_n = 23'(dat_in.y >> 7);
    end else if (dat_in.y[RSQ_YF-1]) begin
      e_n = dat_in.ebase;
      m_n = 23'(dat_in.y >> 6);
    end else begin
      e_n = dat_in.ebase - 8'd1;
      m_n = 23'(dat_in.y >> 5);
    end
  end

  always_comb begin
    inv_d  = 1'b0;
    dz_d   = 1'b0;
    bits_d = QNAN_DFLT;
    unique case (dat_in.cls)
      CLS_NORM:  bits_d = {1'b0, e_n, m_n};
      CLS_PZERO: begin bits_d = PINF; dz_d = 1'b1; end
      CLS_NZERO: begin bits_d = NINF; dz_d = 1'b1; end
      CLS_NEG:   inv_d = 1'b1;
      CLS_PINF:  bits_d = 32'h0000_0000;
      CLS_QNAN:  bits_d = QNAN_DFLT;
      CLS_SNAN:  inv_d = 1'b1;
      default:   inv_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld     <= 1'b0;
      res_bits    <= '0;
      res_invalid <= 1'b0;
      res_divzero <= 1'b0;
    end else begin
      res_vld <= vld_in;
      if (vld_in) begin
        res_bits    <= bits_d;
        res_invalid <= inv_d;
        res_divzero <= dz_d;
      end
    end
  end

  p_divzero_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_divzero |-> res_bits[30:0] == 31'h7F80_0000);

  p_invalid_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_invalid |-> res_bits == QNAN_DFLT);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_invalid && res_divzero));

  p_norm_finite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in && dat_in.cls == CLS_NORM |=>
      !res_bits[31] && res_bits[30:23] != 8'h00 && res_bits[30:23] != 8'hFF);

endmodule

// File: rtl/rsq_unit.sv
module rsq_unit
  import rsq_pkg::*;
#(
  parameter int NR_STEPS = 2,
  parameter int IDX_W    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_vld,
  input  logic [31:0] op_bits,
  output logic        res_vld,
  output logic [31:0] res_bits,
  output logic        res_invalid,
  output logic        res_divzero
);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic      vld_c [NR_STEPS+1];
  rsq_data_t dat_c [NR_STEPS+1];

  rsq_decode #(.IDX_W(IDX_W)) u_decode (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .in_vld (op_vld),
    .in_op  (op_bits),
    .vld_q  (vld_c[0]),
    .dat_q  (dat_c[0])
  );

  for (genvar gs = 0; gs < NR_STEPS; gs++) begin : g_nr
    rsq_nr_step u_step (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .vld_in (vld_c[gs]),
      .dat_in (dat_c[gs]),
      .vld_q  (vld_c[gs+1]),
      .dat_q  (dat_c[gs+1])
    );
  end

  rsq_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .vld_in      (vld_c[NR_STEPS]),
    .dat_in      (dat_c[NR_STEPS]),
    .res_vld     (res_vld),
    .res_bits    (res_bits),
    .res_invalid (res_invalid),
    .res_divzero (res_divzero)
  );

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_int_n |-> !res_vld && !res_invalid && !res_divzero);

endmodule

// File: tb/rsq_unit_tb_top.sv
`timescale 1ns/1ps
module rsq_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_vld;
  logic [31:0] op_bits;
  logic        res_vld;
  logic [31:0] res_bits;
  logic        res_invalid;
  logic        res_divzero;

  int nchk = 0;
  int nerr = 0;

  logic        hv  [4];
  logic [31:0] hop [4];
  logic [31:0] last_res;
  logic        last_inv, last_dz;

  always #2 clk = ~clk;

  rsq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_bits(op_bits),
    .res_vld(res_vld), .res_bits(res_bits),
    .res_invalid(res_invalid), .res_divzero(res_divzero)
  );

  function automatic real pow2(input int k);
    real v = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) v = v * 2.0;
    else        for (int i = 0; i < -k; i++) v = v / 2.0;
    return v;
  endfunction

  function automatic real to_real(input logic [31:0] b);
    real m;
    m = 1.0 + real'(int'(b[22:0])) / 8388608.0;
    return m * pow2(int'(b[30:23]) - 127);
  endfunction

  // returns 1 for special operands and fills the fixed expectation
  function automatic bit ref_special(input logic [31:0] op, output logic [31:0] eb,
                                     output logic ei, output logic ed, output string rq);
    ei = 1'b0; ed = 1'b0; eb = 32'h7FC0_0000; rq = "R2";
    if (op[30:23] == 8'hFF && op[22:0] != 0) begin
      if (op[22]) rq = "R7"; else begin rq = "R8"; ei = 1'b1; end
      return 1'b1;
    end
    if (op[30:23] == 8'h00) begin
      ed = 1'b1;
      if (op[31]) begin eb = 32'hFF80_0000; rq = "R4"; end
      else        begin eb = 32'h7F80_0000; rq = "R3"; end
      return 1'b1;
    end
    if (op[31]) begin ei = 1'b1; rq = "R5"; return 1'b1; end
    if (op[30:23] == 8'hFF) begin eb = 32'h0; rq = "R6"; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic check_out();
    logic [31:0] eb; logic ei, ed; string rq;
    real r, got, err, t, bnd; int e;
    nchk++;
    if (!hv[3]) begin
      if (res_vld !== 1'b0 || res_bits !== last_res || res_invalid !== last_inv ||
          res_divzero !== last_dz) begin
        nerr++;
        $display("FAIL R1/R10 idle: got vld=%b res=%h inv=%b dz=%b exp vld=0 res=%h inv=%b dz=%b",
                 res_vld, res_bits, res_invalid, res_divzero, last_res, last_inv, last_dz);
      end
      return;
    end
    if (res_vld !== 1'b1) begin
      nerr++;
      $display("FAIL R1 op=%h: got vld=%b exp 1", hop[3], res_vld);
      return;
    end
    if (ref_special(hop[3], eb, ei, ed, rq)) begin
      if (res_bits !== eb || res_invalid !== ei || res_divzero !== ed) begin
        nerr++;
        $display("FAIL %s op=%h: got res=%h inv=%b dz=%b exp res=%h inv=%b dz=%b",
                 rq, hop[3], res_bits, res_invalid, res_divzero, eb, ei, ed);
      end
    end else begin
      // R2: error bound against the exact value
      r = 1.0 / $sqrt(to_real(hop[3]));
      t = r; e = 0;
      while (t >= 2.0) begin t = t / 2.0; e++; end
      while (t < 1.0)  begin t = t * 2.0; e--; end
      bnd = pow2(e - 21);
      got = to_real(res_bits);
      err = (got > r) ? got - r : r - got;
      if (res_bits[31] || res_bits[30:23] == 8'h00 || res_invalid || res_divzero || err > bnd) begin
        nerr++;
        $display("FAIL R2 op=%h: got res=%h (%e) inv=%b dz=%b exp %e within %e",
                 hop[3], res_bits, got, res_invalid, res_divzero, r, bnd);
      end
    end
    last_res = res_bits; last_inv = res_invalid; last_dz = res_divzero;
  endtask

  task automatic step(input logic v, input logic [31:0] op);
    @(negedge clk);
    check_out();
    for (int i = 3; i > 0; i--) begin hv[i] = hv[i-1]; hop[i] = hop[i-1]; end
    hv[0] = v; hop[0] = op;
    op_vld = v; op_bits = op;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  logic [31:0] directed [24] = '{
    32'h3F80_0000, 32'h4080_0000, 32'h4000_0000, 32'h3E80_0000,  // 1, 4, 2, 0.25
    32'h7F7F_FFFF, 32'h0080_0000, 32'h3FFF_FFFF, 32'h407F_FFFF,  // extremes, near 2, near 4
    32'h3F7F_FFFF, 32'h4040_0000, 32'h0000_0000, 32'h0000_0001,  // R3 zero/denormal
    32'h8000_0000, 32'h807F_FFFF, 32'hBF80_0000, 32'hFF80_0000,  // R4 / R5
    32'h7F80_0000, 32'h7FC0_0000, 32'hFFC0_0001, 32'h7F80_0001,  // R6 / R7 / R8
    32'hFFA0_0000, 32'h0100_0000, 32'h3FBF_FFFF, 32'h4100_0000
  };

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog: got no end of run, exp end before 200000 cycles");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] op; int sel;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hop[i] = '0; end
    last_res = '0; last_inv = 1'b0; last_dz = 1'b0;
    rst_n = 1'b0; op_vld = 1'b0; op_bits = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    nchk++; if (res_vld !== 1'b0) begin nerr++; $display("FAIL R9 vld: got %b exp 0", res_vld); end
    nchk++; if (res_bits !== 32'h0) begin nerr++; $display("FAIL R9 res: got %h exp 00000000", res_bits); end
    nchk++; if (res_invalid !== 1'b0 || res_divzero !== 1'b0) begin
      nerr++; $display("FAIL R9 flags: got inv=%b dz=%b exp 0 0", res_invalid, res_divzero); end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed corners, back to back (R1) then with gaps (R10)
    foreach (directed[i]) step(1'b1, directed[i]);
    foreach (directed[i]) begin step(1'b1, directed[i]); step(1'b0, 32'hDEAD_BEEF); end
    // constrained random mix of all classes
    for (int n = 0; n < 4000; n++) begin
      sel = int'($urandom % 16);
      if (sel == 0)      op = directed[$urandom % 24];
      else if (sel == 1) op = {1'b1, 8'($urandom % 255 + 1), 23'($urandom)};
      else if (sel == 2) op = {1'($urandom), 8'hFF, 23'($urandom)};
      else if (sel == 3) op = {1'($urandom), 8'h00, 23'($urandom)};
      else if (sel == 4) op = {1'b0, 8'($urandom % 254 + 1), 23'h7FFFFF};
      else               op = {1'b0, 8'($urandom % 254 + 1), 23'($urandom)};
      step(($urandom % 5) != 0, op);
    end
    for (int n = 0; n < 6; n++) step(1'b0, 32'h0);
    summary();
    $finish;
  end

endmodule